// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned `WIDTH`-bit operands over several clocks and returns a `2*WIDTH`-bit product. With the default `WIDTH` of 32 it has one multiplicand register, one 32-bit adder and one 64-bit product register. At the start, the multiplier sits in the lower half of the product register. On each iteration the block examines bit 0 of the product register. When that bit is 1, it adds the multiplicand into the upper half. The whole register then shifts right by one place. The adder's carry out enters the top bit during the shift, so no product bit is lost. The multiplier bits are used up from the low end as the product grows into the register, so no separate multiplier register exists.

A one-cycle `start` pulse loads the operands while the block is not running. The add and the shift happen in the same clock, so the block is busy for exactly `WIDTH` cycles after the load cycle. It then raises `done` and holds the result until the next accepted start.

The controller has three states. `IDLE` is the state after reset. `RUN` is the state in which iterations are performed. `FINISH` is the state in which the result is held. The transitions are:
- LAUNCH: `IDLE` to `RUN` on `start`.
- COMPLETE: `RUN` to `FINISH` after the last iteration.
- RELAUNCH: `FINISH` to `RUN` on `start`.

A `start` seen in `RUN` causes no transition.

Top module: `seq_umul`

## Requirements
- R1: While reset is asserted, and after it is released without a start, `busy` and `done` are 0 and `prod_hi`/`prod_lo` are all zeros.
- R2: A `start` sampled at a clock edge while `busy` is 0 gives, after that edge, `busy`=1, `done`=0, `prod_hi`=0 and `prod_lo` equal to the sampled `op_b`.
- R3: After an accepted start, `busy` stays 1 for exactly WIDTH (32) clock cycles. `done` rises in the same edge in which `busy` falls.
- R4: When `done` is 1, `{prod_hi, prod_lo}` equals the unsigned product `op_a*op_b` of the operands captured at the accepted start. `prod_hi` holds bits 63:32 and `prod_lo` holds bits 31:0.
- R5: The carry out of every add is retained, so full-scale operands give the exact result. For example, 0xFFFFFFFF*0xFFFFFFFF gives 0xFFFFFFFE_00000001.
- R6: A `start` asserted while `busy` is 1 is ignored. The operands in flight, the result and the completion time are unchanged.
- R7: `done` stays 1, and the product outputs stay unchanged, for as long as no new `start` arrives.
- R8: A `start` while `done` is 1 is accepted and launches a new multiplication, with `done` falling after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request; accepted only when not busy |
| op_a | input | WIDTH | Multiplicand, captured on accepted start |
| op_b | input | WIDTH | Multiplier, captured on accepted start |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | High while a finished result is held |
| prod_hi | output | WIDTH | Upper half of the product register |
| prod_lo | output | WIDTH | Lower half of the product register |

## Verification
The hardest case to reach from the ports is an add whose carry out is set in almost every iteration. Only large multiplicands that meet runs of 1s in the multiplier produce it. The stimulus therefore multiplies all-ones by all-ones, and also a top-bit-only multiplicand by all-ones.

A second awkward case is a start that arrives in the middle of a run. The bench launches an operation, waits a few cycles, then pulses `start` with different operands. A reference model that runs every cycle must still see the first product emerge exactly on schedule.

// File: rtl/seq_umul_pkg.sv
package seq_umul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } mul_state_e;

endpackage

// File: rtl/seq_umul_ctrl.sv
module seq_umul_ctrl
    import seq_umul_pkg::*;
#(
    parameter int ITERS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

    mul_state_e       state_q, state_d;
    logic [CNT_W-1:0] iter_q;

    // state register and iteration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) begin
                iter_q <= iter_q + 1'b1;
            end else begin
                iter_q <= '0;
            end
        end
    end

    // next-state: LAUNCH, COMPLETE, RELAUNCH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RUN;
            ST_RUN:    if (iter_q == LAST) state_d = ST_FINISH;
            ST_FINISH: if (start) state_d = ST_RUN;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_RUN:    begin step = 1'b1; busy = 1'b1; end
            ST_FINISH: begin load = start; done = 1'b1; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/seq_umul_adder.sv
module seq_umul_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] mcand,
    input  logic             en,
    output logic [WIDTH:0]   sum
);
    logic [WIDTH-1:0] addend;

    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
        assign addend[i] = mcand[i] & en;
    end

    assign sum = {1'b0, acc} + {1'b0, addend};

endmodule

// File: rtl/seq_umul_dp.sv
module seq_umul_dp #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    prod_q;
    logic [WIDTH:0]   sum;

    seq_umul_adder #(.WIDTH(WIDTH)) u_add (
        .acc   (prod_q[PW-1:WIDTH]),
        .mcand (mcand_q),
        .en    (prod_q[0]),
        .sum   (sum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= op_a;
            prod_q  <= {{WIDTH{1'b0}}, op_b};
        end else if (step) begin
            // carry lands in the top bit as the register shifts right
            prod_q <= {sum, prod_q[WIDTH-1:1]};
        end
    end

    assign hi = prod_q[PW-1:WIDTH];
    assign lo = prod_q[WIDTH-1:0];

endmodule

// File: rtl/seq_umul.sv
module seq_umul #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] prod_hi,
    output logic [WIDTH-1:0] prod_lo
);
    logic load, step;

    seq_umul_ctrl #(.ITERS(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    seq_umul_dp #(.WIDTH(WIDTH)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .op_a  (op_a),
        .op_b  (op_b),
        .hi    (prod_hi),
        .lo    (prod_lo)
    );

endmodule

// File: rtl/seq_umul_chk.sv
module seq_umul_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] op_b,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] prod_hi,
    input logic [WIDTH-1:0] prod_lo
);
    localparam int CW = $clog2(WIDTH + 1) + 1;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R3
    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && prod_hi == '0
                              && prod_lo == $past(op_b))); // R2
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < CW'(WIDTH))); // R3
    AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == CW'(WIDTH) && done)); // R3
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(prod_hi) && $stable(prod_lo))); // R7
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (busy && !done)); // R8
    AST_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && run_cnt < CW'(WIDTH - 1)) |=> busy); // R6

endmodule

bind seq_umul seq_umul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
);

// File: tb/seq_umul_bench.sv
module seq_umul_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         busy, done;
    logic [W-1:0] prod_hi, prod_lo;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // reference model state
    bit           m_busy = 0, m_done = 0;
    int           m_cnt = 0;
    logic [63:0]  m_exp = '0;

    always #2.5 clk = ~clk;

    seq_umul u_seq_umul (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_exp = '0;
        end else if (start && !m_busy) begin
            m_busy = 1; m_done = 0; m_cnt = 0;
            m_exp = 64'(op_a) * 64'(op_b);
        end else if (m_busy) begin
            m_cnt++;
            if (m_cnt == W) begin m_busy = 0; m_done = 1; end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R3 busy", 64'(busy), 64'(m_busy));
            chk(done == m_done, "R7 done", 64'(done), 64'(m_done));
            if (m_done)
                chk({prod_hi, prod_lo} == m_exp, "R4 product",
                    {prod_hi, prod_lo}, m_exp);
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_wait();
        repeat (W + 2) @(negedge clk);
    endtask

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        launch(a, b);
        // one edge after accepted start
        chk(busy && !done && prod_hi == '0 && prod_lo == b, "R2 load",
            {prod_hi, prod_lo}, {32'h0, b});
        finish_wait();
        chk(done && {prod_hi, prod_lo} == 64'(a) * 64'(b), tag,
            {prod_hi, prod_lo}, 64'(a) * 64'(b));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && {prod_hi, prod_lo} == '0, "R1 in reset",
            {prod_hi, prod_lo}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && {prod_hi, prod_lo} == '0, "R1 after reset",
            {prod_hi, prod_lo}, 64'h0);

        run_op(32'd2, 32'd3, "R4 small");
        run_op(32'h1234_5678, 32'h9ABC_DEF0, "R4 mixed");
        run_op(32'h0, 32'hDEAD_BEEF, "R4 zero mcand");
        run_op(32'hCAFE_F00D, 32'h0, "R4 zero mplier");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 full scale");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, "R5 top bit");

        // R7: result held with no start
        repeat (10) @(negedge clk);
        chk(done && {prod_hi, prod_lo} == 64'h7FFF_FFFF_8000_0000, "R7 hold",
            {prod_hi, prod_lo}, 64'h7FFF_FFFF_8000_0000);

        // R6: start during run is ignored
        launch(32'd1000, 32'd77);
        repeat (5) @(negedge clk);
        op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R6 still busy", 64'(busy), 64'h1);
        repeat (W - 7) @(negedge clk);
        chk(busy && !done, "R6 not early", 64'(done), 64'h0);
        @(negedge clk);
        chk(done && {prod_hi, prod_lo} == 64'd77000, "R6 result kept",
            {prod_hi, prod_lo}, 64'd77000);

        // R8: restart from done
        launch(32'd65535, 32'd65537);
        chk(busy && !done, "R8 relaunch", 64'(done), 64'h0);
        finish_wait();
        chk(done && {prod_hi, prod_lo} == 64'hFFFF_FFFF, "R8 result",
            {prod_hi, prod_lo}, 64'hFFFF_FFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule